// File: doc/BRIEF.md
# Repeated Multiply-Accumulate Sequencer

This block is a multi-cycle engine that walks two operand arrays in memory side by side. It multiplies each pair of elements as signed values and adds the product into a running sum. The sum is 96 bits wide and held as three 32-bit words, of which 80 bits are significant. A single start strobe supplies the two base pointers, an element count, the element size and the starting value of the sum. The engine then issues one read per operand through a simple synchronous read port, whose data returns one cycle after the request.

When the count reaches zero, the engine sign-extends the top word from its bit 15. It derives a sign flag and an overflow flag from the fixed top word and raises a one-cycle done pulse. The final sum words, the advanced pointers, the exhausted count and an estimate of the cycle cost stay on the outputs until the next start.

Top module: `rmac_engine`

## Requirements
- R1: After reset all outputs are zero and the engine is idle. A start seen while idle loads the pointers, the count, the element size and the three sum words, and busy is high from the next cycle until the done cycle.
- R2: Each element pair takes three cycles. A read at the first pointer is followed by a read at the second pointer in the next cycle, and then a cycle with no read. Read data is taken from mem_rdata one cycle after its request.
- R3: elem_size encodes 00 as byte, 01 as halfword, and 10 or 11 as word. The element is the low 8, 16 or 32 bits of mem_rdata, sign-extended. Both pointers advance by 1, 2 or 4 after each element.
- R4: The signed 64-bit product of each pair is sign-extended and added to the three-word sum, with carries passed from the low word to the middle word and from the middle word to the high word.
- R5: The count drops by one per element and the loop ends when it reaches zero, so count_left is zero in the done cycle.
- R6: On completion the high word is replaced by the sign extension of its low 16 bits.
- R7: flag_sign equals bit 31 of the fixed high word. flag_ovf is set when the fixed high word is neither all zeros nor all ones.
- R8: A start with a zero count makes no read, keeps the low and middle words, applies the fix-up of R6, and pulses done in the second cycle after the start edge.
- R9: done is high for exactly one cycle, during which busy is low. For n elements it is seen 3n+1 cycles after the first busy cycle.
- R10: A start while busy is ignored: the read sequence and the results are those of the run already under way.
- R11: cycle_cost holds the estimate made at start from the count n: 6+4n for words, 6+5*floor(n/2)+4*(n mod 2) for halfwords and 6+7*floor(n/4)+4*(n mod 4) for bytes.
- R12: A start in the done cycle is accepted and begins a new run at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, taken only while idle |
| base_a | input | ADDR_W | First operand array address |
| base_b | input | ADDR_W | Second operand array address |
| elem_count | input | CNT_W | Number of element pairs |
| elem_size | input | 2 | Element size code |
| init_lo | input | 32 | Starting sum, low word |
| init_mid | input | 32 | Starting sum, middle word |
| init_hi | input | 32 | Starting sum, high word |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read address |
| acc_lo | output | 32 | Sum, low word |
| acc_mid | output | 32 | Sum, middle word |
| acc_hi | output | 32 | Sum, high word |
| ptr_a | output | ADDR_W | Current first pointer |
| ptr_b | output | ADDR_W | Current second pointer |
| count_left | output | CNT_W | Remaining element count |
| flag_ovf | output | 1 | High word out of the 80-bit range |
| flag_sign | output | 1 | Sign of the final sum |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| cycle_cost | output | CNT_W+3 | Cycle cost estimate of the run |

## Verification
The done pulse and the acceptance of a new start can fall in the same cycle, because the engine is already idle while done is high. The bench raises start for a second run in exactly the done cycle of the first. In that cycle it checks every result of the first run, and from the next cycle it checks the read sequence and the final values of the second run against its own model. The opposite case is also provoked: start is raised with different operands in the middle of a run and must leave both the reads and the results unchanged.

// File: rtl/rmac_pkg.sv
// Shared types and helpers for the multiply-accumulate sequencer.
// Assumes 32-bit memory words and a sum of three such words.
package rmac_pkg;

    localparam int WORD_W    = 32;
    localparam int SUM_WORDS = 3;
    localparam int SUM_W     = WORD_W * SUM_WORDS;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } elem_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RDA,
        ST_RDB,
        ST_ACC,
        ST_FIX
    } seq_state_e;

    // Byte stride of one element.
    function automatic logic [2:0] size_bytes(elem_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Sign-extend the element held in the low bits of a read word.
    function automatic logic [WORD_W-1:0] sign_widen(logic [WORD_W-1:0] raw, elem_size_e s);
        case (s)
            SZ_BYTE: return {{(WORD_W-8){raw[7]}}, raw[7:0]};
            SZ_HALF: return {{(WORD_W-16){raw[15]}}, raw[15:0]};
            default: return raw;
        endcase
    endfunction

endpackage

// File: rtl/rmac_ctrl.sv
// Sequencing control: idle, read first operand, read second operand,
// accumulate, final fix-up. Assumes the read port answers one cycle
// after each request. A start is accepted only in the idle state.
module rmac_ctrl
    import rmac_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_empty,
    input  logic [CNT_W-1:0] count_cur,
    output logic             load,
    output logic             rd_a,
    output logic             rd_b,
    output logic             acc_en,
    output logic             fix_en,
    output logic             busy,
    output logic             done
);

    seq_state_e state_q, state_d;
    logic       done_q;
    logic       last_elem;

    assign last_elem = (count_cur == CNT_W'(1));

    // Next-state and strobe decode.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        rd_a    = 1'b0;
        rd_b    = 1'b0;
        acc_en  = 1'b0;
        fix_en  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = start_empty ? ST_FIX : ST_RDA;
                end
            end
            ST_RDA: begin
                rd_a    = 1'b1;
                state_d = ST_RDB;
            end
            ST_RDB: begin
                rd_b    = 1'b1;
                state_d = ST_ACC;
            end
            ST_ACC: begin
                acc_en  = 1'b1;
                state_d = last_elem ? ST_FIX : ST_RDA;
            end
            ST_FIX: begin
                fix_en  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_FIX);
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;

endmodule

// File: rtl/rmac_operand.sv
// Operand capture and signed multiply. Holds the first element, which
// arrives while the second read is issued, and multiplies it by the
// second element as it arrives. Both are sign-extended to a word first.
module rmac_operand
    import rmac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_a,
    input  elem_size_e               size_sel,
    input  logic [WORD_W-1:0]        mem_rdata,
    output logic signed [2*WORD_W-1:0] product
);

    logic [WORD_W-1:0] a_raw_q;
    logic [WORD_W-1:0] a_ext;
    logic [WORD_W-1:0] b_ext;

    // Hold the first element of the pair.
    always_ff @(posedge clk) begin
        if (!rst_n) a_raw_q <= '0;
        else if (cap_a) a_raw_q <= mem_rdata;
    end

    // Widen both elements and form the full signed product.
    always_comb begin
        a_ext   = sign_widen(a_raw_q, size_sel);
        b_ext   = sign_widen(mem_rdata, size_sel);
        product = $signed({{WORD_W{a_ext[WORD_W-1]}}, a_ext})
                * $signed({{WORD_W{b_ext[WORD_W-1]}}, b_ext});
    end

endmodule

// File: rtl/rmac_accum.sv
// Three-word accumulator. It adds a sign-extended product with a
// ripple carry from word to word, and at the end folds the top word to
// SIG_BITS significant bits and derives the sign and overflow flags.
// Assumes SIG_BITS lies inside the top word.
module rmac_accum
    import rmac_pkg::*;
#(
    parameter int SIG_BITS = 80
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [SUM_W-1:0]          init_sum,
    input  logic                      acc_en,
    input  logic signed [2*WORD_W-1:0] product,
    input  logic                      fix_en,
    output logic [SUM_W-1:0]          sum,
    output logic                      flag_ovf,
    output logic                      flag_sign
);

    localparam int TOP_KEEP = SIG_BITS - (SUM_WORDS - 1) * WORD_W;
    localparam int TOP_LSB  = (SUM_WORDS - 1) * WORD_W;

    logic [SUM_W-1:0]     sum_q;
    logic [SUM_W-1:0]     sum_nx;
    logic [SUM_W-1:0]     addend;
    logic [SUM_WORDS-1:0] cy;
    logic [WORD_W-1:0]    top_fixed;

    assign addend = {{(SUM_W - 2*WORD_W){product[2*WORD_W-1]}}, product};
    assign cy[0]  = 1'b0;

    // Word-sliced adders with the carry rippled upward.
    for (genvar g = 0; g < SUM_WORDS; g++) begin : g_word
        if (g < SUM_WORDS - 1) begin : g_mid
            assign {cy[g+1], sum_nx[g*WORD_W +: WORD_W]} =
                {1'b0, sum_q[g*WORD_W +: WORD_W]}
              + {1'b0, addend[g*WORD_W +: WORD_W]}
              + {{WORD_W{1'b0}}, cy[g]};
        end else begin : g_top
            assign sum_nx[g*WORD_W +: WORD_W] =
                sum_q[g*WORD_W +: WORD_W]
              + addend[g*WORD_W +: WORD_W]
              + {{(WORD_W-1){1'b0}}, cy[g]};
        end
    end

    assign top_fixed = {{(WORD_W - TOP_KEEP){sum_q[TOP_LSB + TOP_KEEP - 1]}},
                        sum_q[TOP_LSB +: TOP_KEEP]};

    // Sum register: load, accumulate or fold the top word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (load) begin
            sum_q <= init_sum;
        end else if (acc_en) begin
            sum_q <= sum_nx;
        end else if (fix_en) begin
            sum_q[TOP_LSB +: WORD_W] <= top_fixed;
        end
    end

    // Flags, cleared at start and set from the folded top word.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            flag_ovf  <= 1'b0;
            flag_sign <= 1'b0;
        end else if (fix_en) begin
            flag_ovf  <= (top_fixed != '0) && (top_fixed != '1);
            flag_sign <= top_fixed[WORD_W-1];
        end
    end

    assign sum = sum_q;

endmodule

// File: rtl/rmac_cost.sv
// Cycle cost estimate, computed once from the count and size at start.
module rmac_cost
    import rmac_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int COST_W = CNT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  count_in,
    input  elem_size_e        size_sel,
    output logic [COST_W-1:0] cost
);

    logic [COST_W-1:0] n_ext;
    logic [COST_W-1:0] cost_b;
    logic [COST_W-1:0] cost_h;
    logic [COST_W-1:0] cost_w;

    // Per-size formulas.
    always_comb begin
        n_ext  = COST_W'(count_in);
        cost_b = COST_W'(6) + COST_W'(7) * (n_ext >> 2) + ((n_ext & COST_W'(3)) << 2);
        cost_h = COST_W'(6) + COST_W'(5) * (n_ext >> 1) + ((n_ext & COST_W'(1)) << 2);
        cost_w = COST_W'(6) + (n_ext << 2);
    end

    // Register the estimate at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cost <= '0;
        end else if (load) begin
            case (size_sel)
                SZ_BYTE: cost <= cost_b;
                SZ_HALF: cost <= cost_h;
                default: cost <= cost_w;
            endcase
        end
    end

endmodule

// File: rtl/rmac_engine.sv
// Repeated multiply-accumulate sequencer, top level. It walks two arrays,
// multiplies paired elements as signed values and sums them into a
// three-word accumulator. Assumes a read port with fixed one-cycle
// latency and no back-pressure.
module rmac_engine
    import rmac_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 32,
    parameter int SIG_BITS = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_a,
    input  logic [ADDR_W-1:0] base_b,
    input  logic [CNT_W-1:0]  elem_count,
    input  logic [1:0]        elem_size,
    input  logic [31:0]       init_lo,
    input  logic [31:0]       init_mid,
    input  logic [31:0]       init_hi,
    input  logic [31:0]       mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       acc_lo,
    output logic [31:0]       acc_mid,
    output logic [31:0]       acc_hi,
    output logic [ADDR_W-1:0] ptr_a,
    output logic [ADDR_W-1:0] ptr_b,
    output logic [CNT_W-1:0]  count_left,
    output logic              flag_ovf,
    output logic              flag_sign,
    output logic              busy,
    output logic              done,
    output logic [CNT_W+2:0]  cycle_cost
);

    localparam int COST_W = CNT_W + 3;

    logic                       load, rd_a, rd_b, acc_en, fix_en;
    elem_size_e                 size_q;
    logic [ADDR_W-1:0]          ptr_a_q, ptr_b_q, stride;
    logic [CNT_W-1:0]           count_q;
    logic signed [2*WORD_W-1:0] product;
    logic [SUM_W-1:0]           sum;

    rmac_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_empty (elem_count == '0),
        .count_cur   (count_q),
        .load        (load),
        .rd_a        (rd_a),
        .rd_b        (rd_b),
        .acc_en      (acc_en),
        .fix_en      (fix_en),
        .busy        (busy),
        .done        (done)
    );

    rmac_operand u_operand (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_a     (rd_b),
        .size_sel  (size_q),
        .mem_rdata (mem_rdata),
        .product   (product)
    );

    rmac_accum #(.SIG_BITS(SIG_BITS)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .init_sum  ({init_hi, init_mid, init_lo}),
        .acc_en    (acc_en),
        .product   (product),
        .fix_en    (fix_en),
        .sum       (sum),
        .flag_ovf  (flag_ovf),
        .flag_sign (flag_sign)
    );

    rmac_cost #(.CNT_W(CNT_W), .COST_W(COST_W)) u_cost (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .count_in (elem_count),
        .size_sel (elem_size_e'(elem_size)),
        .cost     (cycle_cost)
    );

    assign stride = ADDR_W'(size_bytes(size_q));

    // Element size, latched for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n) size_q <= SZ_BYTE;
        else if (load) size_q <= elem_size_e'(elem_size);
    end

    // Pointers and count: loaded at start, stepped after each pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_a_q <= '0;
            ptr_b_q <= '0;
            count_q <= '0;
        end else if (load) begin
            ptr_a_q <= base_a;
            ptr_b_q <= base_b;
            count_q <= elem_count;
        end else if (acc_en) begin
            ptr_a_q <= ptr_a_q + stride;
            ptr_b_q <= ptr_b_q + stride;
            count_q <= count_q - CNT_W'(1);
        end
    end

    assign mem_req    = rd_a | rd_b;
    assign mem_addr   = rd_a ? ptr_a_q : ptr_b_q;
    assign acc_lo     = sum[0 +: WORD_W];
    assign acc_mid    = sum[WORD_W +: WORD_W];
    assign acc_hi     = sum[2*WORD_W +: WORD_W];
    assign ptr_a      = ptr_a_q;
    assign ptr_b      = ptr_b_q;
    assign count_left = count_q;

endmodule

// File: rtl/rmac_engine_chk.sv
// Property checker for the sequencer, bound to the top module.
module rmac_engine_chk #(
    parameter int CNT_W    = 32,
    parameter int TOP_KEEP = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             mem_req,
    input logic [CNT_W-1:0] count_left,
    input logic [31:0]      acc_hi,
    input logic             flag_ovf,
    input logic             flag_sign
);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_read_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_count_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (count_left == '0));

    assert_top_folded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc_hi == {{(32-TOP_KEEP){acc_hi[TOP_KEEP-1]}}, acc_hi[TOP_KEEP-1:0]}));

    assert_sign_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_sign == acc_hi[31]));

    assert_ovf_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_ovf == ((acc_hi != '0) && (acc_hi != '1))));

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (count_left <= $past(count_left)));

endmodule

bind rmac_engine rmac_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .mem_req    (mem_req),
    .count_left (count_left),
    .acc_hi     (acc_hi),
    .flag_ovf   (flag_ovf),
    .flag_sign  (flag_sign)
);

// File: tb/rmac_engine_test.sv
`timescale 1ns/1ps
module rmac_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_a = '0, base_b = '0;
    logic [31:0] elem_count = '0;
    logic [1:0]  elem_size = '0;
    logic [31:0] init_lo = '0, init_mid = '0, init_hi = '0;
    logic [31:0] mem_rdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] acc_lo, acc_mid, acc_hi, ptr_a, ptr_b, count_left;
    logic        flag_ovf, flag_sign, busy, done;
    logic [34:0] cycle_cost;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Memory content model
    int          mem_mode = 0;
    logic [31:0] mem_key = 32'h0;
    logic [31:0] mem_const = 32'h0;

    // Globals describing the run being tracked
    logic [31:0] g_a, g_b;
    int          g_n;
    logic [1:0]  g_sz;
    logic [95:0] g_init;

    always #2 clk = ~clk;

    rmac_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .base_a(base_a), .base_b(base_b), .elem_count(elem_count),
        .elem_size(elem_size), .init_lo(init_lo), .init_mid(init_mid),
        .init_hi(init_hi), .mem_rdata(mem_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .acc_lo(acc_lo), .acc_mid(acc_mid),
        .acc_hi(acc_hi), .ptr_a(ptr_a), .ptr_b(ptr_b),
        .count_left(count_left), .flag_ovf(flag_ovf), .flag_sign(flag_sign),
        .busy(busy), .done(done), .cycle_cost(cycle_cost)
    );

    function automatic logic [31:0] memf(logic [31:0] addr);
        if (mem_mode == 1) return mem_const;
        return (addr * 32'h9E3779B1) ^ {addr[12:0], 19'h0} ^ mem_key;
    endfunction

    // Read port with one cycle of latency
    always @(posedge clk) if (mem_req) mem_rdata <= memf(mem_addr);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int stride_of(logic [1:0] sz);
        return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    endfunction

    function automatic longint elem_of(logic [31:0] raw, logic [1:0] sz);
        longint v;
        if (sz == 2'b00) v = $signed(raw[7:0]);
        else if (sz == 2'b01) v = $signed(raw[15:0]);
        else v = $signed(raw);
        return v;
    endfunction

    task automatic launch(input logic [31:0] a, input logic [31:0] b, input int n,
                          input logic [1:0] sz, input logic [95:0] init);
        g_a = a; g_b = b; g_n = n; g_sz = sz; g_init = init;
        base_a = a; base_b = b; elem_count = n; elem_size = sz;
        {init_hi, init_mid, init_lo} = init;
        start = 1'b1;
    endtask

    // Follows one run cycle by cycle and checks the results in the done cycle
    task automatic track(input bit inject);
        logic [95:0] acc;
        logic [31:0] top;
        longint      p, cost;
        int          sd;
        sd  = stride_of(g_sz);
        acc = g_init;
        for (int e = 0; e < g_n; e++) begin
            p   = elem_of(memf(g_a + e * sd), g_sz) * elem_of(memf(g_b + e * sd), g_sz);
            acc = acc + {{32{p[63]}}, p};
        end
        top = {{16{acc[79]}}, acc[79:64]};
        if (g_sz == 2'b00) cost = 6 + 7 * (g_n / 4) + 4 * (g_n % 4);
        else if (g_sz == 2'b01) cost = 6 + 5 * (g_n / 2) + 4 * (g_n % 2);
        else cost = 6 + 4 * g_n;

        @(posedge clk); @(negedge clk);
        start = 1'b0;
        for (int j = 0; j <= 3 * g_n + 1; j++) begin
            if (j > 0) begin @(posedge clk); @(negedge clk); end
            if (inject && j == 2) start = 1'b0;
            chk("R1 busy", busy, (j <= 3 * g_n));
            chk("R9 done", done, (j == 3 * g_n + 1));
            chk("R2 mem_req", mem_req, (j < 3 * g_n) && (j % 3 != 2));
            if (j < 3 * g_n && j % 3 == 0) chk("R2 addr A", mem_addr, g_a + (j / 3) * sd);
            if (j < 3 * g_n && j % 3 == 1) chk("R2 addr B", mem_addr, g_b + (j / 3) * sd);
            if (inject && j == 1) begin
                // R10: start while busy with other operands must be ignored
                base_a = 32'h5555_0000; base_b = 32'h6666_0000;
                elem_count = 7; elem_size = 2'b00; start = 1'b1;
            end
        end
        chk("R4 acc_lo", acc_lo, acc[31:0]);
        chk("R4 acc_mid", acc_mid, acc[63:32]);
        chk("R6 acc_hi", acc_hi, top);
        chk("R3 ptr_a", ptr_a, g_a + g_n * sd);
        chk("R3 ptr_b", ptr_b, g_b + g_n * sd);
        chk("R5 count_left", count_left, 0);
        chk("R7 flag_sign", flag_sign, top[31]);
        chk("R7 flag_ovf", flag_ovf, (top != 32'h0) && (top != 32'hFFFF_FFFF));
        chk("R11 cycle_cost", cycle_cost, cost[34:0]);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset mem_req", mem_req, 0);
        chk("R1 reset acc", {acc_hi, acc_mid}, 0);
        chk("R1 reset count", count_left, 0);
        chk("R1 reset cost", cycle_cost, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4: word elements, pseudo-random data
        mem_mode = 0; mem_key = 32'h1357_9BDF;
        launch(32'h0000_1000, 32'h0000_2000, 5, 2'b10, 96'h0);
        track(0);
        @(negedge clk);

        // R3: halfword elements from a positive start value
        mem_key = 32'hA5A5_0F0F;
        launch(32'h0000_3002, 32'h0000_4006, 7, 2'b01, {32'h0000_0012, 32'h8000_0001, 32'h7000_0000});
        track(0);
        @(negedge clk);

        // R3: byte elements from a sum of all ones
        mem_key = 32'h0BAD_F00D;
        launch(32'h0000_5001, 32'h0000_6003, 9, 2'b00, {96{1'b1}});
        track(0);
        @(negedge clk);

        // R3: the alternative word code
        launch(32'h0000_7000, 32'h0000_7100, 3, 2'b11, 96'h0);
        track(0);
        @(negedge clk);

        // R8: zero count, top word folded, overflow reported
        launch(32'h0000_8000, 32'h0000_9000, 0, 2'b10, {32'h0001_2345, 32'hDEAD_BEEF, 32'hCAFE_F00D});
        track(0);
        @(negedge clk);

        // R4 R7: large products carry into the top word
        mem_mode = 1; mem_const = 32'h8000_0000;
        launch(32'h0000_A000, 32'h0000_B000, 6, 2'b10, 96'h0);
        track(0);
        @(negedge clk);

        // R4: low-word carry into the middle word
        mem_const = 32'h0000_0004;
        launch(32'h0000_A100, 32'h0000_B100, 2, 2'b10, {32'h0, 32'h0, 32'hFFFF_FFF0});
        track(0);
        @(negedge clk);

        // R6 R7: bit 15 of the top word set gives the sign
        mem_const = 32'h0000_0001;
        launch(32'h0000_C000, 32'h0000_C100, 2, 2'b00, {32'h0000_8000, 32'h0, 32'h0});
        track(0);
        @(negedge clk);

        // R10: start during a run is ignored
        mem_mode = 0; mem_key = 32'h2468_ACE0;
        launch(32'h0000_D000, 32'h0000_E000, 4, 2'b10, 96'h0);
        track(1);
        @(negedge clk);

        // R12: a new start in the done cycle
        launch(32'h0001_0000, 32'h0001_1000, 3, 2'b01, 96'h5);
        track(0);
        launch(32'h0001_2000, 32'h0001_3000, 2, 2'b00, 96'h0);
        track(0);
        @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule